// File: doc/BRIEF.md
# Polled Keyboard Character Port

This block sits between a processor bus and a keyboard-like character source. Software starts a character fetch by writing a command value to a control/status location. It then polls that location until the top bit of the returned byte is 1, and reads the character from a separate data location. The character source has only a one-cycle valid strobe with an 8-bit byte.

The two registers can be decoded in either of two ways, chosen by a mode input. In shared-space mode they answer ordinary memory read and write strobes at addresses 516 (data) and 517 (control/status). In separate-space mode they answer only dedicated I/O read and write strobes, at I/O addresses 5 (data) and 6 (control/status). A character that arrives when no fetch is outstanding is discarded and leaves a sticky error flag. Read data is combinational from the address and strobes. The internal reset is asserted asynchronously and released on a clock edge.

Top module: `keyin_port`

## Requirements
- R1: After reset both registers read 0x00: no fetch is outstanding, the ready flag and the lost-byte flag are clear, and the held character is 0x00.
- R2: When `iso_mode` is 0, the data register answers at address 516 and the control/status register at address 517, through `mem_rd`/`mem_wr` only. `io_rd`/`io_wr` accesses read 0x00 and change nothing.
- R3: When `iso_mode` is 1, the data register answers at address 5 and the control/status register at address 6, through `io_rd`/`io_wr` only. `mem_rd`/`mem_wr` accesses read 0x00 and change nothing.
- R4: A write of 0x01 to the control/status register starts a fetch: the ready flag and the lost-byte flag clear, and a fetch becomes outstanding. A write of any other value to it, or any write to the data register, changes nothing.
- R5: A `kb_valid` pulse while a fetch is outstanding stores `kb_byte` and sets the ready flag from the next cycle. The fetch is then no longer outstanding.
- R6: A control/status read returns bit 7 = ready flag, bit 0 = lost-byte flag, and bits 6..1 = 0.
- R7: A data-register read returns the held character. From the next cycle the ready flag is clear.
- R8: A `kb_valid` pulse with no fetch outstanding leaves the held character unchanged and sets the lost-byte flag. That flag stays set until the next start write.
- R9: When a start write and a `kb_valid` pulse fall in the same cycle, the start takes effect. That byte is neither stored nor counted as lost.
- R10: `rdata` is 0x00 in any cycle with no read of a decoded register, including reads of any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_mode | input | 1 | 0: memory-space decoding, 1: I/O-space decoding |
| addr | input | 16 | Bus address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when nothing decoded |
| kb_valid | input | 1 | One-cycle character valid from the device |
| kb_byte | input | 8 | Character from the device |

## Verification
The hardest cases to reach are those where device timing collides with software. One is a character that lands in the same cycle as a start command. The other is a character that lands after the previous one was captured but before software has restarted. The stimulus drives the device strobe and the bus write in the same half-cycle window to produce the collision. It also sends back-to-back characters after a capture, so that the lost-byte flag must appear while the held byte stays intact. A full address sweep in both modes and with both strobe kinds runs with the ready and lost-byte flags set. This shows that only the four decoded locations respond, and that a data read clears the ready flag partway through the sweep.

// File: rtl/keyin_pkg.sv
package keyin_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CSR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/keyin_decode.sv
module keyin_decode
  import keyin_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int MEM_DATA_ADDR = 516,
  parameter int MEM_CSR_ADDR  = 517,
  parameter int IO_DATA_ADDR  = 5,
  parameter int IO_CSR_ADDR   = 6
) (
  input  logic              iso_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  output reg_sel_e          rd_sel,
  output reg_sel_e          wr_sel
);
  localparam logic [ADDR_W-1:0] MEM_DATA = MEM_DATA_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] MEM_CSR  = MEM_CSR_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] IO_DATA  = IO_DATA_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] IO_CSR   = IO_CSR_ADDR[ADDR_W-1:0];

  logic rd_en, wr_en, data_hit, csr_hit;

  // Only the strobe pair that belongs to the selected space is honoured.
  always_comb begin
    rd_en    = iso_mode ? io_rd : mem_rd;
    wr_en    = iso_mode ? io_wr : mem_wr;
    data_hit = (addr == (iso_mode ? IO_DATA : MEM_DATA));
    csr_hit  = (addr == (iso_mode ? IO_CSR  : MEM_CSR));
  end

  always_comb begin
    rd_sel = SEL_NONE;
    wr_sel = SEL_NONE;
    if (rd_en && data_hit) rd_sel = SEL_DATA;
    else if (rd_en && csr_hit) rd_sel = SEL_CSR;
    if (wr_en && data_hit) wr_sel = SEL_DATA;
    else if (wr_en && csr_hit) wr_sel = SEL_CSR;
  end

  // The two register addresses of one space must never alias.
  always_comb begin
    assert_distinct_R2: assert (!(data_hit && csr_hit));
  end
endmodule

// File: rtl/keyin_state.sv
module keyin_state
  import keyin_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int START_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          rd_sel,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_byte,
  output logic              ready,
  output logic              overrun,
  output logic [DATA_W-1:0] data_q
);
  localparam logic [DATA_W-1:0] START_VAL = START_CODE[DATA_W-1:0];

  logic start, pend_q, pend_d, ready_q, ready_d, ovr_q, ovr_d, data_en;

  // Next-state logic
  always_comb begin
    start   = (wr_sel == SEL_CSR) && (wdata == START_VAL);
    data_en = !start && kb_valid && pend_q;
    pend_d  = pend_q;
    ready_d = ready_q;
    ovr_d   = ovr_q;
    if (start) begin
      pend_d  = 1'b1;
      ready_d = 1'b0;
      ovr_d   = 1'b0;
    end else begin
      if (rd_sel == SEL_DATA) ready_d = 1'b0;
      if (kb_valid) begin
        if (pend_q) begin
          ready_d = 1'b1;
          pend_d  = 1'b0;
        end else begin
          ovr_d = 1'b1;
        end
      end
    end
  end

  // Flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
    end
  end

  // Character holding register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (data_en) data_q <= kb_byte;
  end

  assign ready   = ready_q;
  assign overrun = ovr_q;

  // A fetch is either waiting or already done, never both
  assert_pend_ready_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && ready_q));

  assert_start_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pend_q && !ready_q && !ovr_q));

  assert_ready_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(kb_valid && pend_q && !start));

  assert_lost_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && !pend_q && !start) |=> ovr_q);

  assert_data_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_DATA && !kb_valid && !start) |=> !ready_q);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(kb_valid && pend_q && !start) |=> $stable(data_q));
endmodule

// File: rtl/keyin_rdmux.sv
module keyin_rdmux
  import keyin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  reg_sel_e          rd_sel,
  input  logic              ready,
  input  logic              overrun,
  input  logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status;

  always_comb begin
    status           = '0;
    status[DATA_W-1] = ready;
    status[0]        = overrun;
  end

  always_comb begin
    case (rd_sel)
      SEL_DATA: rdata = data_q;
      SEL_CSR:  rdata = status;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyin_port.sv
module keyin_port
  import keyin_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int MEM_DATA_ADDR = 516,
  parameter int MEM_CSR_ADDR  = 517,
  parameter int IO_DATA_ADDR  = 5,
  parameter int IO_CSR_ADDR   = 6,
  parameter int START_CODE    = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iso_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_byte
);
  reg_sel_e rd_sel, wr_sel;
  logic ready, overrun;
  logic [DATA_W-1:0] data_q;
  logic [SYNC_STAGES-1:0] rst_sync;
  logic core_rst_n;

  // Reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync[SYNC_STAGES-1];

  keyin_decode #(
    .ADDR_W(ADDR_W), .MEM_DATA_ADDR(MEM_DATA_ADDR), .MEM_CSR_ADDR(MEM_CSR_ADDR),
    .IO_DATA_ADDR(IO_DATA_ADDR), .IO_CSR_ADDR(IO_CSR_ADDR)
  ) u_decode (
    .iso_mode(iso_mode), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  keyin_state #(.DATA_W(DATA_W), .START_CODE(START_CODE)) u_state (
    .clk(clk), .rst_n(core_rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .wdata(wdata), .kb_valid(kb_valid), .kb_byte(kb_byte),
    .ready(ready), .overrun(overrun), .data_q(data_q)
  );

  keyin_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .rd_sel(rd_sel), .ready(ready), .overrun(overrun), .data_q(data_q),
    .rdata(rdata)
  );

  // Nothing decoded means a quiet bus
  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_sel == SEL_NONE) |-> (rdata == '0));

  // Status middle bits are always zero
  assert_status_fmt_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_sel == SEL_CSR) |-> (rdata[DATA_W-2:1] == '0));
endmodule

// File: tb/test_keyin_port.sv
module test_keyin_port;
  logic clk = 1'b0;
  logic rst_n;
  logic iso_mode, mem_rd, mem_wr, io_rd, io_wr, kb_valid;
  logic [15:0] addr;
  logic [7:0] wdata, rdata, kb_byte;

  int n_chk = 0;
  int n_fail = 0;

  bit m_ready, m_pend, m_ovr, m_iso;
  logic [7:0] m_data;

  always #4 clk = ~clk;

  keyin_port i_keyin_port (
    .clk(clk), .rst_n(rst_n), .iso_mode(iso_mode), .addr(addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .wdata(wdata), .rdata(rdata), .kb_valid(kb_valid), .kb_byte(kb_byte)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int data_loc();
    return m_iso ? 5 : 516;
  endfunction
  function automatic int csr_loc();
    return m_iso ? 6 : 517;
  endfunction

  function automatic logic [7:0] exp_rd(input bit use_io, input int a);
    if (use_io != m_iso) return 8'h00;
    if (a == data_loc()) return m_data;
    if (a == csr_loc()) return {m_ready, 6'b0, m_ovr};
    return 8'h00;
  endfunction

  task automatic set_mode(input bit iso);
    @(negedge clk);
    iso_mode = iso;
    m_iso = iso;
  endtask

  task automatic rd(input bit use_io, input int a, input string req);
    logic [7:0] e;
    e = exp_rd(use_io, a);
    @(negedge clk);
    addr = a[15:0];
    if (use_io) io_rd = 1'b1; else mem_rd = 1'b1;
    #1 chk(rdata, e, req);
    @(posedge clk);
    #1;
    io_rd = 1'b0; mem_rd = 1'b0; addr = '0;
    if (use_io == m_iso && a == data_loc()) m_ready = 1'b0;
  endtask

  task automatic wr(input bit use_io, input int a, input logic [7:0] v, input bit with_kb,
                    input logic [7:0] b);
    @(negedge clk);
    addr = a[15:0];
    wdata = v;
    if (use_io) io_wr = 1'b1; else mem_wr = 1'b1;
    kb_valid = with_kb;
    kb_byte = b;
    @(posedge clk);
    #1;
    io_wr = 1'b0; mem_wr = 1'b0; kb_valid = 1'b0; addr = '0; wdata = '0;
    if (use_io == m_iso && a == csr_loc() && v == 8'h01) begin
      m_pend = 1'b1; m_ready = 1'b0; m_ovr = 1'b0;
    end else if (with_kb) begin
      if (m_pend) begin m_data = b; m_ready = 1'b1; m_pend = 1'b0; end
      else m_ovr = 1'b1;
    end
  endtask

  task automatic start_cmd();
    wr(m_iso, csr_loc(), 8'h01, 1'b0, 8'h00);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    kb_valid = 1'b1;
    kb_byte = b;
    @(posedge clk);
    #1 kb_valid = 1'b0;
    if (m_pend) begin m_data = b; m_ready = 1'b1; m_pend = 1'b0; end
    else m_ovr = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iso_mode = 1'b0; addr = '0; wdata = '0; kb_byte = '0;
    mem_rd = 1'b0; mem_wr = 1'b0; io_rd = 1'b0; io_wr = 1'b0; kb_valid = 1'b0;
    m_ready = 0; m_pend = 0; m_ovr = 0; m_iso = 0; m_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents
    rd(1'b0, 517, "R1 status");
    chk(rdata, 8'h00, "R10 idle");
    rd(1'b0, 516, "R1 data");

    // R5/R6/R7 sweep over every character value in both spaces (R2, R3)
    for (int md = 0; md < 2; md++) begin
      set_mode(md[0]);
      for (int b = 0; b < 256; b++) begin
        start_cmd();
        rd(m_iso, csr_loc(), "R4 status after start");
        push(b[7:0]);
        rd(m_iso, csr_loc(), "R5 R6 ready set");
        rd(m_iso, data_loc(), m_iso ? "R3 R7 data" : "R2 R7 data");
        rd(m_iso, csr_loc(), "R7 ready cleared");
      end
    end

    // R8: bytes with nothing outstanding are lost and flagged, sticky
    set_mode(1'b0);
    push(8'h5A);
    rd(1'b0, 517, "R8 lost flag");
    rd(1'b0, 516, "R8 data kept");
    push(8'hC3);
    rd(1'b0, 517, "R8 lost flag sticky");
    start_cmd();
    rd(1'b0, 517, "R8 R4 start clears lost flag");

    // R4: non-start values and data-register writes do nothing
    push(8'h11);
    for (int v = 0; v < 256; v++)
      if (v != 1) wr(1'b0, 517, v[7:0], 1'b0, 8'h00);
    wr(1'b0, 516, 8'h01, 1'b0, 8'h00);
    push(8'h22);
    rd(1'b0, 517, "R4 no start from other values");
    rd(1'b0, 516, "R4 data unchanged");

    // R2: I/O strobes ignored in memory mode; R3: memory strobes ignored in I/O mode
    wr(1'b1, 6, 8'h01, 1'b0, 8'h00);
    wr(1'b1, 517, 8'h01, 1'b0, 8'h00);
    push(8'h33);
    rd(1'b0, 516, "R2 io write ignored");
    rd(1'b1, 5, "R2 io read quiet");
    set_mode(1'b1);
    wr(1'b0, 517, 8'h01, 1'b0, 8'h00);
    wr(1'b0, 6, 8'h01, 1'b0, 8'h00);
    push(8'h44);
    rd(1'b1, 5, "R3 mem write ignored");
    rd(1'b0, 6, "R3 mem read quiet");
    rd(1'b1, 6, "R3 status");

    // R9: start and byte in the same cycle
    for (int md = 0; md < 2; md++) begin
      set_mode(md[0]);
      push(8'h66);
      wr(m_iso, csr_loc(), 8'h01, 1'b1, 8'h77);
      rd(m_iso, csr_loc(), "R9 start wins");
      push(8'h88);
      rd(m_iso, data_loc(), "R9 later byte taken");
      rd(m_iso, csr_loc(), "R9 status after");
    end

    // R10: address sweep with ready and lost flags set, both modes and strobe kinds
    for (int md = 0; md < 2; md++) begin
      set_mode(md[0]);
      start_cmd();
      push(8'hA5);
      push(8'h3C);
      for (int k = 0; k < 2; k++)
        for (int a = 0; a < 1024; a++)
          rd(k[0], a, "R10 sweep");
    end
    @(negedge clk);
    chk(rdata, 8'h00, "R10 idle end");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule